// File: doc/BRIEF.md
# Per-CPU level-one interrupt controller

This block gathers a number of 32-bit groups of level-sensitive interrupt source lines and sends them to as many as two processors. Each processor has its own register bank. A bank holds one enable word and one status word for every group of 32 sources. A processor's single interrupt output goes high when at least one source is both asserted and enabled in that processor's bank.

Software reads and writes the banks through a plain 32-bit register port that has valid, write, address and data signals. An enable word is written as a whole, so setting or clearing one source takes a read-modify-write. Status words show the live level of each source line. Software ANDs a status word with its own enable word to find which sources are pending for it. The hardware allows the same source to be enabled in both banks at once. It is up to software to choose a single target for each source.

Top module: `l1_irq_ctrl`

## Requirements
- R1: After reset every enable word reads as zero and both `cpuIrq` outputs are low.
- R2: The register address is a byte address and bits [1:0] are not decoded. CPU c owns the range from byte c×8×NUM_WORDS up to, but not including, (c+1)×8×NUM_WORDS. Within a bank, enable slot k is at byte offset 4k and status slot k is at byte offset 4×NUM_WORDS+4k, for k = 0..NUM_WORDS-1. Slot k serves group NUM_WORDS-1-k. Bit b of group g corresponds to `irqSrc[32g+b]`.
- R3: A write to an enable slot replaces the whole 32-bit enable word. A later read of that slot returns the value that was written.
- R4: A read of a status slot returns the live levels of that group's 32 source lines. Both CPUs' banks return the same status value.
- R5: Writes to status slots are ignored. Enable words and outputs do not change.
- R6: A read at a word address at or beyond NUM_CPUS×2×NUM_WORDS returns zero. A write there changes nothing.
- R7: `cpuIrq[c]` is registered. On each clock edge it takes the OR, across all groups, of (source levels AND CPU c's enable word). A change becomes visible one cycle later.
- R8: The two banks are independent. The same source bit may be enabled in both banks, and then both outputs assert.
- R9: Reset is synchronous and active-high. When asserted during operation it clears all enable words and both outputs at the next clock edge.
- R10: `regRData` is combinational. It is zero whenever no read is presented (`regValid` low or `regWrite` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte address of the access |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data, same cycle |
| irqSrc | input | NUM_WORDS×32 | Level-sensitive source lines |
| cpuIrq | output | NUM_CPUS | Per-CPU interrupt outputs |

## Verification
The hardest case to reach is proving that the reversed word order is correct end to end. A write to a given enable slot must gate the intended source group, and no other group. The bench drives the sources one group at a time, enables matching and non-matching bit patterns in each bank, and checks each output one cycle later. It also checks that a write to a status slot, or to an address beyond the banks, leaves the enable words and an already asserted output untouched. It does this by reading the enable words back and watching the output while the source is held high.

// File: rtl/l1_irq_pkg.sv
package l1_irq_pkg;
  localparam int CPU_W_MAX = 1;   // up to two CPUs
  localparam int GRP_W_MAX = 4;   // up to sixteen groups
  localparam int REG_W     = 32;

  typedef struct packed {
    logic                 hit;       // address lies inside a bank
    logic                 rdEn;      // read presented
    logic                 wrEn;      // write to an enable slot
    logic                 wrDrop;    // write that must have no effect
    logic                 isStatus;  // status slot selected
    logic [CPU_W_MAX-1:0] cpu;
    logic [GRP_W_MAX-1:0] group;     // interrupt group, already reversed
  } regStrobe_t;
endpackage

// File: rtl/l1_irq_decode.sv
module l1_irq_decode
  import l1_irq_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);
  localparam int BANK_WORDS  = 2 * NUM_WORDS;
  localparam int TOTAL_WORDS = NUM_CPUS * BANK_WORDS;
  localparam int WA_W        = ADDR_W - 2;

  logic [WA_W-1:0] wordIdx;
  int unsigned     wIdx;
  int unsigned     cpuIdx;
  int unsigned     offIdx;
  int unsigned     slotIdx;
  logic            inRange;

  assign wordIdx = regAddr[ADDR_W-1:2];

  always_comb begin
    wIdx    = 32'(wordIdx);
    cpuIdx  = wIdx / BANK_WORDS;
    offIdx  = wIdx % BANK_WORDS;
    inRange = (wIdx < TOTAL_WORDS);
    slotIdx = (offIdx >= NUM_WORDS) ? offIdx - NUM_WORDS : offIdx;

    strb          = '0;
    strb.hit      = inRange;
    strb.isStatus = (offIdx >= NUM_WORDS);
    strb.cpu      = CPU_W_MAX'(cpuIdx);
    strb.group    = GRP_W_MAX'(NUM_WORDS - 1 - slotIdx);
    strb.rdEn     = regValid && !regWrite;
    strb.wrEn     = regValid && regWrite && inRange && (offIdx < NUM_WORDS);
    strb.wrDrop   = regValid && regWrite && !(inRange && (offIdx < NUM_WORDS));
  end

  // R2: a decoded hit always names an existing CPU and group
  a_r2_hit_in_bank: assert property (@(posedge clk) disable iff (rst)
    strb.hit |-> (int'(strb.cpu) < NUM_CPUS) && (int'(strb.group) < NUM_WORDS));
endmodule

// File: rtl/l1_irq_datapath.sv
module l1_irq_datapath
  import l1_irq_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int NUM_CPUS  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  regStrobe_t                 strb,
  input  logic [REG_W-1:0]           regWData,
  input  logic [NUM_WORDS*REG_W-1:0] irqSrc,
  output logic [REG_W-1:0]           regRData,
  output logic [NUM_CPUS-1:0]        cpuIrq
);
  localparam int SRC_W = NUM_WORDS * REG_W;

  logic [REG_W-1:0] enReg   [NUM_CPUS][NUM_WORDS];
  logic [REG_W-1:0] srcWord [NUM_WORDS];
  logic [SRC_W-1:0] enFlat  [NUM_CPUS];
  logic [NUM_CPUS-1:0] pendAny;

  genvar gi, ci;
  generate
    for (gi = 0; gi < NUM_WORDS; gi++) begin : g_split
      assign srcWord[gi] = irqSrc[gi*REG_W +: REG_W];
    end
    for (ci = 0; ci < NUM_CPUS; ci++) begin : g_cpu
      for (gi = 0; gi < NUM_WORDS; gi++) begin : g_word
        always_ff @(posedge clk) begin
          if (rst)
            enReg[ci][gi] <= '0;
          else if (strb.wrEn && int'(strb.cpu) == ci && int'(strb.group) == gi)
            enReg[ci][gi] <= regWData;
        end
        assign enFlat[ci][gi*REG_W +: REG_W] = enReg[ci][gi];
      end

      assign pendAny[ci] = |(irqSrc & enFlat[ci]);

      always_ff @(posedge clk) begin
        if (rst) cpuIrq[ci] <= 1'b0;
        else     cpuIrq[ci] <= pendAny[ci];
      end

      // R1 / R9: reset leaves the bank empty and the output low
      a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (enFlat[ci] == '0) && !cpuIrq[ci]);
      // R7: a bank with nothing enabled cannot raise its output next cycle
      a_r7_no_enable_quiet: assert property (@(posedge clk) disable iff (rst)
        (enFlat[ci] == '0) |=> !cpuIrq[ci]);
      // R5 / R6: dropped writes leave every enable word untouched
      a_r5_drop_stable: assert property (@(posedge clk) disable iff (rst)
        (strb.wrDrop && !strb.wrEn) |=> $stable(enFlat[ci]));
    end
  endgenerate

  always_comb begin
    regRData = '0;
    if (strb.rdEn && strb.hit) begin
      for (int c = 0; c < NUM_CPUS; c++) begin
        for (int g = 0; g < NUM_WORDS; g++) begin
          if (int'(strb.cpu) == c && int'(strb.group) == g)
            regRData = strb.isStatus ? srcWord[g] : enReg[c][g];
        end
      end
    end
  end

  // R6 / R10: nothing decoded, nothing returned
  a_r6_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !(strb.rdEn && strb.hit) |-> (regRData == '0));
endmodule

// File: rtl/l1_irq_ctrl.sv
module l1_irq_ctrl
  import l1_irq_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       regValid,
  input  logic                       regWrite,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [REG_W-1:0]           regWData,
  output logic [REG_W-1:0]           regRData,
  input  logic [NUM_WORDS*REG_W-1:0] irqSrc,
  output logic [NUM_CPUS-1:0]        cpuIrq
);
  regStrobe_t strb;

  l1_irq_decode #(
    .NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)
  ) u_decode (
    .clk(clk), .rst(rst), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .strb(strb)
  );

  l1_irq_datapath #(
    .NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS)
  ) u_datapath (
    .clk(clk), .rst(rst), .strb(strb), .regWData(regWData),
    .irqSrc(irqSrc), .regRData(regRData), .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/l1_irq_ctrl_bench.sv
module l1_irq_ctrl_bench;
  localparam int N  = 4;
  localparam int NC = 2;
  localparam int AW = 8;
  localparam int NV = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regValid = 1'b0, regWrite = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic [N*32-1:0] irqSrc = '0;
  logic [NC-1:0] cpuIrq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  l1_irq_ctrl #(.NUM_WORDS(N), .NUM_CPUS(NC), .ADDR_W(AW)) u_l1_irq_ctrl (
    .clk(clk), .rst(rst), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWData(regWData), .regRData(regRData),
    .irqSrc(irqSrc), .cpuIrq(cpuIrq)
  );

  // vector table: group, cpu0 enable, cpu1 enable, source word, expected {irq1,irq0}
  localparam int          VG   [NV] = '{0, 3, 1, 2, 1, 0};
  localparam logic [31:0] VEN0 [NV] = '{32'h1, 32'h0, 32'hF0, 32'hFFFF0000, 32'hAAAAAAAA, 32'h0000FFFF};
  localparam logic [31:0] VEN1 [NV] = '{32'h0, 32'h80000000, 32'h0F, 32'hFFFF0000, 32'h55555555, 32'h0};
  localparam logic [31:0] VSRC [NV] = '{32'h1, 32'h80000000, 32'h0F, 32'h00010000, 32'h0, 32'hFFFF0000};
  localparam logic [1:0]  VEXP [NV] = '{2'b01, 2'b10, 2'b10, 2'b11, 2'b00, 2'b00};

  function automatic logic [AW-1:0] enAddr(int c, int g);
    return AW'(c*8*N + 4*(N-1-g));
  endfunction
  function automatic logic [AW-1:0] stAddr(int c, int g);
    return AW'(c*8*N + 4*N + 4*(N-1-g));
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    regValid = 1; regWrite = 1; regAddr = a; regWData = d;
    @(negedge clk);
    regValid = 0; regWrite = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    regValid = 1; regWrite = 0; regAddr = a;
    #1 d = regRData;
    regValid = 0;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (2) @(negedge clk);
    rst = 0;

    // R1: reset state
    check("R1 irq after reset", 32'(cpuIrq), 32'h0);
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < N; g++) begin
        rd(enAddr(c, g), d);
        check("R1 enable zero", d, 32'h0);
      end
    // R10: idle read data is zero
    @(negedge clk); regAddr = stAddr(0, 0); irqSrc = '1; #1;
    check("R10 idle rdata", regRData, 32'h0);
    irqSrc = '0;

    // R2 / R3: each enable slot keeps its own word
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < N; g++) wr(enAddr(c, g), 32'hC0DE0000 | 32'(c*16 + g));
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < N; g++) begin
        rd(enAddr(c, g), d);
        check("R3 enable readback", d, 32'hC0DE0000 | 32'(c*16 + g));
      end
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < N; g++) wr(enAddr(c, g), 32'h0);

    // R2 / R4 / R7 / R8: table walk
    for (int v = 0; v < NV; v++) begin
      wr(enAddr(0, VG[v]), VEN0[v]);
      wr(enAddr(1, VG[v]), VEN1[v]);
      irqSrc = '0;
      irqSrc[VG[v]*32 +: 32] = VSRC[v];
      #1 check("R7 output before edge", 32'(cpuIrq), 32'h0);
      @(negedge clk);
      check("R7 R8 R2 output", 32'(cpuIrq), 32'(VEXP[v]));
      rd(stAddr(0, VG[v]), d);
      check("R4 status cpu0", d, VSRC[v]);
      rd(stAddr(1, VG[v]), d);
      check("R4 status cpu1", d, VSRC[v]);
      wr(enAddr(0, VG[v]), 32'h0);
      wr(enAddr(1, VG[v]), 32'h0);
      irqSrc = '0;
      @(negedge clk);
    end

    // R5: status writes are dropped
    wr(enAddr(0, 2), 32'h00000100);
    irqSrc[2*32 + 8] = 1'b1;
    @(negedge clk);
    check("R5 irq set", 32'(cpuIrq), 32'h1);
    wr(stAddr(0, 2), 32'h0);
    wr(stAddr(1, 2), 32'hFFFFFFFF);
    @(negedge clk);
    check("R5 irq unchanged", 32'(cpuIrq), 32'h1);
    rd(enAddr(0, 2), d);
    check("R5 enable kept", d, 32'h00000100);
    rd(enAddr(1, 2), d);
    check("R5 other bank kept", d, 32'h0);
    rd(stAddr(0, 2), d);
    check("R5 status live", d, 32'h00000100);

    // R6: out-of-range accesses
    wr(AW'(NC*8*N), 32'hFFFFFFFF);
    wr(AW'(8'hFC), 32'hFFFFFFFF);
    rd(AW'(NC*8*N), d);
    check("R6 read beyond banks", d, 32'h0);
    rd(AW'(8'hFC), d);
    check("R6 read top", d, 32'h0);
    rd(enAddr(0, 2), d);
    check("R6 enable kept", d, 32'h00000100);
    @(negedge clk);
    check("R6 irq kept", 32'(cpuIrq), 32'h1);

    // R9: mid-run reset
    wr(enAddr(1, 2), 32'h00000100);
    @(negedge clk);
    check("R9 both asserted", 32'(cpuIrq), 32'h3);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R9 irq cleared", 32'(cpuIrq), 32'h0);
    rd(enAddr(0, 2), d);
    check("R9 enable cleared cpu0", d, 32'h0);
    rd(enAddr(1, 2), d);
    check("R9 enable cleared cpu1", d, 32'h0);
    @(negedge clk);
    check("R9 irq stays low", 32'(cpuIrq), 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule